// File: doc/BRIEF.md
# Quad-Output Memory Read Slave

This block is the device side of a serial memory interface that serves one command: a fast read that returns data on four pins at once. A system clock oversamples chip select, the serial clock and the four data pins. On the pins the block takes in a one-byte opcode and a 24-bit address on the lowest data line. It then takes a mode byte spread over all four lines and waits a configurable number of dummy cycles. After that it streams bytes from a synchronous memory port, four bits per serial clock, with the high nibble first.

The mode byte selects a continuation state. When it holds one of two marker values, the next chip-select cycle starts with the address and no opcode is sent, which saves eight clocks on every random access. Any other mode value brings the block back to opcode decoding once chip select deasserts. While the serial clock keeps running, the read address advances through the whole array and wraps from the top address to zero. Raising chip select ends the read at any point.

The serial clock must stay high for at least five system clocks and low for at least five. The memory returns data one system clock after a read strobe.

Top module: `qspi_xip_reader`

## Requirements
- R1: After reset the data pins are not driven (io_oe low) and no memory read is issued.
- R2: The opcode is taken MSB first from io_in[0] on eight rising serial-clock edges. Only 0x6B starts a read. Any other value keeps io_oe low until chip select rises, and the next chip-select falling edge decodes an opcode again.
- R3: The address follows as 24 bits, MSB first, on io_in[0]. The upper 5 bits are discarded and the low 19 bits form the byte address.
- R4: The mode byte takes two rising edges. The first carries bits 7..4 on io_in[3:0] and the second carries bits 3..0.
- R5: lat_sel values 0, 1, 2 and 3 insert 0, 2, 4 and 6 dummy cycles after the mode byte.
- R6: The pins stay undriven until the falling edge that opens the first data cycle. From there, io_out changes only after a falling serial-clock edge, giving each byte's bits 7..4 and then bits 3..0.
- R7: Each byte delivered moves the address up by one, and address 0x7FFFF is followed by address 0.
- R8: If the mode byte is 0xEF or 0xAF, the next chip-select cycle starts directly with the 24 address bits. Any other value, including 0xFE, needs an opcode on the next cycle.
- R9: When chip select goes high, io_oe drops, even in the middle of a byte. A new cycle then decodes normally.
- R10: mem_rd is a one-cycle pulse. A read of N whole bytes issues exactly N+1 memory reads, one of them a prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| lat_sel | input | 2 | Static dummy-cycle setting (count = 2 x value) |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| io_in | input | 4 | Data pin input values |
| io_out | output | 4 | Data pin output values |
| io_oe | output | 1 | Output enable for all four data pins |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 19 | Memory byte address |
| mem_rdata | input | 8 | Memory data, valid one clock after mem_rd |

## Verification
The first sweep walks a single one across all 24 address bit positions. It shows that each of the low 19 bits steers the memory address and that the top five bits fold to zero. The second sweep crosses all four latency settings with several start addresses, including one just below the top of the array, so a wrong dummy count or a missed wrap shows up as shifted data. The memory contents are a hash of the address, so a nibble swap or a wrong byte cannot pass by chance. Mode sequences alternate 0xEF, 0xAF, 0xFE and 0x00 between opcode-led and address-led cycles, which separates a correct continuation decision from a swapped mode nibble order. A bad opcode and a chip-select abort in the middle of a byte show that the pins are released.

// File: rtl/qspi_xip_reader.sv
module qspi_xip_reader #(
  parameter int          ADDR_W    = 19,
  parameter int          WIRE_ABITS = 24,
  parameter logic [7:0]  READ_OP   = 8'h6B,
  parameter logic [7:0]  KEEP_A    = 8'hEF,
  parameter logic [7:0]  KEEP_B    = 8'hAF,
  parameter int          SYNC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lat_sel,
  input  logic              cs_n,
  input  logic              sck,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic              io_oe,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  localparam int CW = $clog2(WIRE_ABITS);
  localparam logic [2:0] ST_IDLE = 3'd0, ST_CMD = 3'd1, ST_ADDR = 3'd2,
                         ST_MODE = 3'd3, ST_DUMMY = 3'd4, ST_DATA = 3'd5,
                         ST_IGN = 3'd6;

  logic [SYNC-1:0]      cs_q, sck_q;
  logic [SYNC-1:0][3:0] io_q;
  logic                 cs_d, sck_d;
  logic                 s_cs, s_sck, rise, fall, cs_start;
  logic [3:0]           s_io;

  logic [2:0]        st;
  logic [CW-1:0]     cnt;
  logic [7:0]        sh;
  logic [ADDR_W-1:0] abuf, addr;
  logic [3:0]        mode_hi, lo;
  logic [7:0]        nxt;
  logic              xip, half, rd_d;
  logic [CW-1:0]     dummy_last;
  logic [7:0]        op_full, mode_full;

  assign s_cs      = cs_q[SYNC-1];
  assign s_sck     = sck_q[SYNC-1];
  assign s_io      = io_q[SYNC-1];
  assign rise      = s_sck & ~sck_d;
  assign fall      = ~s_sck & sck_d;
  assign cs_start  = ~s_cs & cs_d;
  assign op_full   = {sh[6:0], s_io[0]};
  assign mode_full = {mode_hi, s_io};
  assign dummy_last = CW'({lat_sel, 1'b0}) - CW'(1);
  assign mem_addr  = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= '1;
      sck_q <= '1;
      io_q  <= '0;
      cs_d  <= 1'b1;
      sck_d <= 1'b1;
    end else begin
      cs_q  <= {cs_q[SYNC-2:0], cs_n};
      sck_q <= {sck_q[SYNC-2:0], sck};
      io_q  <= {io_q[SYNC-2:0], io_in};
      cs_d  <= s_cs;
      sck_d <= s_sck;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      abuf    <= '0;
      addr    <= '0;
      mode_hi <= '0;
      lo      <= '0;
      nxt     <= '0;
      xip     <= 1'b0;
      half    <= 1'b0;
      io_out  <= '0;
      io_oe   <= 1'b0;
      mem_rd  <= 1'b0;
      rd_d    <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      rd_d   <= mem_rd;
      if (rd_d) nxt <= mem_rdata;
      if (s_cs) begin
        st    <= ST_IDLE;
        io_oe <= 1'b0;
      end else if (cs_start) begin
        st  <= xip ? ST_ADDR : ST_CMD;
        cnt <= '0;
      end else if (rise) begin
        case (st)
          ST_CMD: begin
            sh  <= op_full;
            cnt <= cnt + CW'(1);
            if (cnt == CW'(7)) begin
              cnt <= '0;
              st  <= (op_full == READ_OP) ? ST_ADDR : ST_IGN;
            end
          end
          ST_ADDR: begin
            abuf <= {abuf[ADDR_W-2:0], s_io[0]};
            cnt  <= cnt + CW'(1);
            if (cnt == CW'(WIRE_ABITS - 1)) begin
              cnt  <= '0;
              addr <= {abuf[ADDR_W-2:0], s_io[0]};
              st   <= ST_MODE;
            end
          end
          ST_MODE: begin
            if (cnt == '0) begin
              mode_hi <= s_io;
              cnt     <= CW'(1);
            end else begin
              cnt  <= '0;
              xip  <= (mode_full == KEEP_A) || (mode_full == KEEP_B);
              half <= 1'b0;
              if (lat_sel == 2'd0) begin
                st     <= ST_DATA;
                mem_rd <= 1'b1;
              end else begin
                st <= ST_DUMMY;
              end
            end
          end
          ST_DUMMY: begin
            cnt <= cnt + CW'(1);
            if (cnt == dummy_last) begin
              st     <= ST_DATA;
              mem_rd <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (fall && st == ST_DATA) begin
        io_oe <= 1'b1;
        half  <= ~half;
        if (!half) begin
          io_out <= nxt[7:4];
          lo     <= nxt[3:0];
          addr   <= addr + ADDR_W'(1);
          mem_rd <= 1'b1;
        end else begin
          io_out <= lo;
        end
      end
    end
  end
endmodule

// File: rtl/qspi_xip_reader_chk.sv
module qspi_xip_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_cs,
  input logic       sck_fall,
  input logic [2:0] st,
  input logic       io_oe,
  input logic [3:0] io_out,
  input logic       mem_rd
);
  localparam logic [2:0] ST_IGN = 3'd6;

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |=> !io_oe);

  a_r6_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sck_fall) |-> $stable(io_out));

  a_r6_enable_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_oe) |-> $past(sck_fall));

  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  a_r2_quiet_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN) |-> !io_oe);
endmodule

bind qspi_xip_reader qspi_xip_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_cs(s_cs), .sck_fall(fall),
  .st(st), .io_oe(io_oe), .io_out(io_out), .mem_rd(mem_rd)
);

// File: tb/qspi_xip_reader_test.sv
module qspi_xip_reader_test;
  localparam int CLK_NS = 10;
  localparam int HALF   = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lat_sel = 2'd0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b1;
  logic [3:0]  io_in = 4'hF;
  logic [3:0]  io_out;
  logic        io_oe;
  logic        mem_rd;
  logic [18:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;

  int n_chk = 0, n_bad = 0, rd_cnt = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  qspi_xip_reader uut (
    .clk(clk), .rst_n(rst_n), .lat_sel(lat_sel), .cs_n(cs_n), .sck(sck),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [18:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ {5'd0, a[18:16]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= pat(mem_addr);
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] d, output logic [3:0] q, output logic oe);
    @(negedge clk);
    sck = 1'b0;
    io_in = d;
    repeat (HALF - 1) @(negedge clk);
    q = io_out;
    oe = io_oe;
    @(negedge clk);
    sck = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic txn(input bit with_cmd, input logic [7:0] op, input logic [23:0] a,
                     input logic [7:0] mode, input int nb, input bit good,
                     input bit abort_mid, input string req);
    logic [3:0] q, hi;
    logic oe, oe_seen;
    int rd0;
    oe_seen = 1'b0;
    rd0 = rd_cnt;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    if (with_cmd)
      for (int i = 7; i >= 0; i--) begin cyc({3'b111, op[i]}, q, oe); oe_seen |= oe; end
    for (int i = 23; i >= 0; i--) begin cyc({3'b111, a[i]}, q, oe); oe_seen |= oe; end
    cyc(mode[7:4], q, oe); oe_seen |= oe;
    cyc(mode[3:0], q, oe); oe_seen |= oe;
    for (int i = 0; i < 2 * int'(lat_sel); i++) begin cyc(4'hF, q, oe); oe_seen |= oe; end
    chk(!oe_seen, "R6", "pins driven before data phase", oe_seen, 0);
    for (int b = 0; b < nb; b++) begin
      logic [18:0] ea;
      logic oe2;
      ea = a[18:0] + 19'(b);
      cyc(4'hF, hi, oe);
      cyc(4'hF, q, oe2);
      if (good) begin
        chk(oe && oe2, "R6", "output enable in data phase", {oe, oe2}, 3);
        chk({hi, q} == pat(ea), req, "data byte", {hi, q}, pat(ea));
      end else begin
        chk(!oe && !oe2, "R2", "pins driven after bad opcode", {oe, oe2}, 0);
      end
    end
    if (abort_mid) begin
      cyc(4'hF, hi, oe);
      chk(oe && hi == pat(a[18:0] + 19'(nb)) >> 4, "R9", "nibble before abort",
          hi, pat(a[18:0] + 19'(nb)) >> 4);
    end
    @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!io_oe, "R9", "pins released after chip select high", io_oe, 0);
    if (good && !abort_mid && nb > 0)
      chk(rd_cnt - rd0 == nb + 1, "R10", "memory read count", rd_cnt - rd0, nb + 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!io_oe && !mem_rd, "R1", "reset outputs", {io_oe, mem_rd}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!io_oe && rd_cnt == 0, "R1", "idle after reset", {io_oe, rd_cnt[0]}, 0);

    // R3: walk one address bit, upper five fold away
    lat_sel = 2'd1;
    for (int k = 0; k < 24; k++)
      txn(1, 8'h6B, 24'(1) << k, 8'h00, 2, 1, 0, "R3");

    // R5 and R7: latency sweep, several starts including the wrap point
    for (int l = 0; l < 4; l++) begin
      lat_sel = 2'(l);
      txn(1, 8'h6B, 24'h012345, 8'h00, 3, 1, 0, "R5");
      txn(1, 8'h6B, 24'hF7FFFE, 8'h00, 4, 1, 0, "R7");
      txn(1, 8'h6B, 24'h000000, 8'h10, 2, 1, 0, "R5");
    end

    // R2: unknown opcode, then normal decode again
    lat_sel = 2'd2;
    txn(1, 8'h6A, 24'h000100, 8'h00, 2, 0, 0, "R2");
    txn(1, 8'h6B, 24'h000100, 8'h00, 2, 1, 0, "R2");

    // R8 and R4: continuation markers and nibble order
    txn(1, 8'h6B, 24'h03ABCD, 8'hEF, 2, 1, 0, "R8");
    txn(0, 8'h00, 24'h040000, 8'hAF, 2, 1, 0, "R8");
    txn(0, 8'h00, 24'h07FFFF, 8'hFE, 2, 1, 0, "R8");
    txn(1, 8'h6B, 24'h001234, 8'hEF, 2, 1, 0, "R4");
    txn(0, 8'h00, 24'h055555, 8'h00, 2, 1, 0, "R8");
    txn(1, 8'h6B, 24'h022222, 8'hEE, 2, 1, 0, "R4");
    txn(1, 8'h6B, 24'h033333, 8'h00, 1, 1, 0, "R4");

    // R9: abort in the middle of a byte, then restart
    lat_sel = 2'd3;
    txn(1, 8'h6B, 24'h010101, 8'h00, 1, 1, 1, "R9");
    txn(1, 8'h6B, 24'h020202, 8'h00, 2, 1, 0, "R9");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule